// File: doc/BRIEF.md
# Protection Region Configuration Registers

This block is the software-visible register file behind a memory protection unit. It stores the base address, size/enable word and access attributes for a parameterized number of protection regions. It also holds a global control word and reports the region count through a read-only identification word. Only one region is visible to software at a time. A region selector chooses it, and that selector can be written directly or reloaded as a side effect of a base-address write.

The base/attribute register pair is decoded at four aliased address pairs so that software can program several regions with multiple-store sequences. Every alias reaches whichever region is currently selected. Reads are combinational from the address and have no side effects. Writes take effect on the rising clock edge. Each write that actually changes protection state produces a one-cycle invalidate pulse, so that any downstream translation or permission cache can flush. Checking addresses against the regions is handled elsewhere.

Address map (byte offsets, 32-bit words): 0x00 identification, 0x04 control, 0x08 region selector, 0x0C + 8k base alias k, 0x10 + 8k size/attribute alias k, for k = 0..3. Every other offset, including offsets that are not word aligned, is unmapped.

Top module: `prot_region_regs`

## Requirements
- R1: Offset 0x00 reads the region count in bits [15:8] and zero in all other bits. A write there changes nothing and produces no invalidate pulse.
- R2: Offset 0x04 keeps only bits [2:0] of a write (bit 0 enable, bit 1 enable while handling faults, bit 2 default-map enable) and reads them back with bits [31:3] zero. Every write to it produces an invalidate pulse.
- R3: A write to offset 0x08 with a value below the region count loads the selector, which reads back in bits [3:0]. A value at or above the count is dropped and the old selection stays.
- R4: A base write with bit 4 set uses bits [3:0] as the target region and latches it into the selector. If that region is at or above the count, the whole write is discarded: no base change, no selector change, no pulse.
- R5: A base write stores bits [31:5] of the data, with bits [4:0] cleared. A base read returns the stored base of the selected region with the selector value in bits [3:0] and bit 4 zero.
- R6: A size/attribute write stores data[15:0] & 0xFF3F as the size word and data[31:16] & 0x173F as the attribute word. A read returns the attribute word in [31:16] and the size word in [15:0].
- R7: All four alias pairs (base at 0x0C+8k, size/attribute at 0x10+8k) access the same selected region.
- R8: Unmapped offsets read zero, and writes to them change nothing and produce no pulse.
- R9: prot_inval is high for exactly the one cycle after the edge that accepts a control, base or size/attribute write. It stays low after selector, identification, discarded or unmapped writes, and after idle cycles.
- R10: After reset, control, selector and every region's base, size and attribute words are zero, and prot_inval is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_addr | input | ADDR_W | Byte offset for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| prot_inval | output | 1 | One-cycle invalidate pulse after an accepted configuration write |

## Verification
The hardest case to reach from the ports is a base write whose bit 4 redirects to a region number at or above the count. It must leave the selector, every stored base and the invalidate output untouched, and this is only visible through later reads. The random stimulus therefore biases base-write data so that bit 4 is often set and the low nibble often lands in the out-of-range values 8 to 15. A directed case does the same right after a valid redirect, so that a lost selection would be seen. Reads through every alias then compare the selector and region contents against the bench model.

// File: rtl/prr_pkg.sv
package prr_pkg;
   typedef enum logic [2:0] {
      ACC_NONE,
      ACC_IDENT,
      ACC_CTRL,
      ACC_SEL,
      ACC_BASE,
      ACC_ATTR
   } acc_e;

   localparam int SEL_W        = 4;
   localparam int CTRL_W       = 3;
   localparam int BASE_LSB     = 5;
   localparam int REDIR_BIT    = 4;
   localparam int OFS_IDENT    = 'h00;
   localparam int OFS_CTRL     = 'h04;
   localparam int OFS_SEL      = 'h08;
   localparam int OFS_PAIR0    = 'h0C;
   localparam int ALIAS_STRIDE = 8;
   localparam logic [15:0] SIZE_MASK = 16'hFF3F;
   localparam logic [15:0] ATTR_MASK = 16'h173F;
endpackage

// File: rtl/prr_decode.sv
module prr_decode
   import prr_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int NUM_ALIAS = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output acc_e              kind
);
   localparam int SPAN = OFS_PAIR0 + ALIAS_STRIDE * NUM_ALIAS;

   if (SPAN > (1 << ADDR_W)) begin : g_bad_span
      $error("prr_decode: ADDR_W too narrow for the alias pairs");
   end
   if (NUM_ALIAS < 1) begin : g_bad_alias
      $error("prr_decode: NUM_ALIAS must be at least 1");
   end

   logic [NUM_ALIAS-1:0] base_hit;
   logic [NUM_ALIAS-1:0] attr_hit;

   for (genvar k = 0; k < NUM_ALIAS; k++) begin : g_alias
      assign base_hit[k] = (addr == ADDR_W'(OFS_PAIR0 + ALIAS_STRIDE * k));
      assign attr_hit[k] = (addr == ADDR_W'(OFS_PAIR0 + ALIAS_STRIDE * k + 4));
   end

   always_comb begin
      kind = ACC_NONE;
      if (addr == ADDR_W'(OFS_IDENT))      kind = ACC_IDENT;
      else if (addr == ADDR_W'(OFS_CTRL))  kind = ACC_CTRL;
      else if (addr == ADDR_W'(OFS_SEL))   kind = ACC_SEL;
      else if (|base_hit)                  kind = ACC_BASE;
      else if (|attr_hit)                  kind = ACC_ATTR;
   end
endmodule

// File: rtl/prr_ctrl_sel.sv
module prr_ctrl_sel
   import prr_pkg::*;
#(
   parameter int NUM_REGIONS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  acc_e              kind,
   input  logic [31:0]       wdata,
   output logic [SEL_W-1:0]  sel_q,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic [SEL_W-1:0]  wr_idx,
   output logic              base_we,
   output logic              attr_we,
   output logic              accept
);
   logic redir;
   logic idx_ok;
   logic sel_load_ok;
   logic ctrl_we;

   assign redir       = (kind == ACC_BASE) && wdata[REDIR_BIT];
   assign wr_idx      = redir ? wdata[SEL_W-1:0] : sel_q;
   assign idx_ok      = (32'(wr_idx) < 32'(NUM_REGIONS));
   assign sel_load_ok = (wdata < 32'(NUM_REGIONS));
   assign ctrl_we     = wr && (kind == ACC_CTRL);
   assign base_we     = wr && (kind == ACC_BASE) && idx_ok;
   assign attr_we     = wr && (kind == ACC_ATTR) && idx_ok;
   assign accept      = ctrl_we || base_we || attr_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         ctrl_q <= '0;
      end else begin
         if (wr && (kind == ACC_SEL) && sel_load_ok)
            sel_q <= wdata[SEL_W-1:0];
         else if (base_we && redir)
            sel_q <= wdata[SEL_W-1:0];
         if (ctrl_we)
            ctrl_q <= wdata[CTRL_W-1:0];
      end
   end
endmodule

// File: rtl/prr_region_bank.sv
module prr_region_bank
   import prr_pkg::*;
#(
   parameter int NUM_REGIONS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             base_we,
   input  logic             attr_we,
   input  logic [SEL_W-1:0] wr_idx,
   input  logic [31:0]      wdata,
   input  logic [SEL_W-1:0] rd_idx,
   output logic [31:0]      rd_base,
   output logic [31:0]      rd_szattr
);
   localparam int BASE_W = 32 - BASE_LSB;

   logic [NUM_REGIONS-1:0][BASE_W-1:0] base_all;
   logic [NUM_REGIONS-1:0][31:0]       szattr_all;

   for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
      logic [BASE_W-1:0] base_q;
      logic [15:0]       size_q;
      logic [15:0]       attr_q;
      logic              hit;

      assign hit = (wr_idx == SEL_W'(r));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q <= '0;
            size_q <= '0;
            attr_q <= '0;
         end else begin
            if (base_we && hit)
               base_q <= wdata[31:BASE_LSB];
            if (attr_we && hit) begin
               size_q <= wdata[15:0] & SIZE_MASK;
               attr_q <= wdata[31:16] & ATTR_MASK;
            end
         end
      end

      assign base_all[r]   = base_q;
      assign szattr_all[r] = {attr_q, size_q};
   end

   always_comb begin
      rd_base   = '0;
      rd_szattr = '0;
      for (int r = 0; r < NUM_REGIONS; r++) begin
         if (rd_idx == SEL_W'(r)) begin
            rd_base   = {base_all[r], {BASE_LSB{1'b0}}};
            rd_szattr = szattr_all[r];
         end
      end
   end
endmodule

// File: rtl/prot_region_regs.sv
module prot_region_regs
   import prr_pkg::*;
#(
   parameter int NUM_REGIONS = 8,
   parameter int ADDR_W      = 6,
   parameter int NUM_ALIAS   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              prot_inval
);
   if (NUM_REGIONS < 1 || NUM_REGIONS > (1 << SEL_W)) begin : g_bad_count
      $error("prot_region_regs: NUM_REGIONS must be 1..16");
   end

   acc_e              kind;
   logic [SEL_W-1:0]  sel_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic [SEL_W-1:0]  wr_idx;
   logic              base_we;
   logic              attr_we;
   logic              accept;
   logic [31:0]       rd_base;
   logic [31:0]       rd_szattr;
   logic              sel_ok;

   prr_decode #(.ADDR_W(ADDR_W), .NUM_ALIAS(NUM_ALIAS)) u_dec (
      .addr (reg_addr),
      .kind (kind)
   );

   prr_ctrl_sel #(.NUM_REGIONS(NUM_REGIONS)) u_cs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (reg_wr),
      .kind    (kind),
      .wdata   (reg_wdata),
      .sel_q   (sel_q),
      .ctrl_q  (ctrl_q),
      .wr_idx  (wr_idx),
      .base_we (base_we),
      .attr_we (attr_we),
      .accept  (accept)
   );

   prr_region_bank #(.NUM_REGIONS(NUM_REGIONS)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .base_we   (base_we),
      .attr_we   (attr_we),
      .wr_idx    (wr_idx),
      .wdata     (reg_wdata),
      .rd_idx    (sel_q),
      .rd_base   (rd_base),
      .rd_szattr (rd_szattr)
   );

   assign sel_ok = (32'(sel_q) < 32'(NUM_REGIONS));

   always_comb begin
      reg_rdata = '0;
      case (kind)
         ACC_IDENT: reg_rdata = {16'h0, 8'(NUM_REGIONS), 8'h0};
         ACC_CTRL:  reg_rdata = {{(32-CTRL_W){1'b0}}, ctrl_q};
         ACC_SEL:   reg_rdata = {{(32-SEL_W){1'b0}}, sel_q};
         ACC_BASE:  reg_rdata = sel_ok ? (rd_base | {{(32-SEL_W){1'b0}}, sel_q}) : '0;
         ACC_ATTR:  reg_rdata = sel_ok ? rd_szattr : '0;
         default:   reg_rdata = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prot_inval <= 1'b0;
      else        prot_inval <= accept;
   end
endmodule

// File: rtl/prr_checker.sv
module prr_checker
   import prr_pkg::*;
#(
   parameter int NUM_REGIONS = 8,
   parameter int ADDR_W      = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [31:0]       reg_wdata,
   input logic [31:0]       reg_rdata,
   input logic              prot_inval,
   input logic [SEL_W-1:0]  sel_q
);
   // R9: a control write always yields a pulse in the next cycle
   a_r9_ctrl_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(OFS_CTRL)) |=> prot_inval);

   // R9: no write, no pulse
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> !prot_inval);

   // R3: the selector never holds an out-of-range region
   a_r3_sel_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      32'(sel_q) < 32'(NUM_REGIONS));

   // R3: an out-of-range selector write leaves the selection alone
   a_r3_oob_sel_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(OFS_SEL) && reg_wdata >= 32'(NUM_REGIONS))
      |=> $stable(sel_q));

   // R5: base read carries the selector in its low bits, bit 4 clear
   a_r5_base_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(OFS_PAIR0)) |-> (reg_rdata[4:0] == {1'b0, sel_q}));

   // R2: unused control bits read as zero
   a_r2_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(OFS_CTRL)) |-> (reg_rdata[31:CTRL_W] == '0));
endmodule

bind prot_region_regs prr_checker #(
   .NUM_REGIONS (NUM_REGIONS),
   .ADDR_W      (ADDR_W)
) u_prr_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (reg_wr),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .reg_rdata  (reg_rdata),
   .prot_inval (prot_inval),
   .sel_q      (sel_q)
);

// File: tb/prot_region_regs_bench.sv
`timescale 1ns/100ps
module prot_region_regs_bench;
   localparam int N  = 8;
   localparam int AW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          prot_inval;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   // bench model
   logic [3:0]  m_sel;
   logic [2:0]  m_ctrl;
   logic [31:0] m_base [16];
   logic [15:0] m_size [16];
   logic [15:0] m_attr [16];

   always #2.5 clk = ~clk;

   prot_region_regs #(.NUM_REGIONS(N), .ADDR_W(AW)) u_prot_region_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .prot_inval (prot_inval)
   );

   // 0 none, 1 ident, 2 ctrl, 3 sel, 4 base, 5 attr
   function automatic int kind_of(logic [AW-1:0] a);
      if (a == 6'h00) return 1;
      if (a == 6'h04) return 2;
      if (a == 6'h08) return 3;
      for (int k = 0; k < 4; k++) begin
         if (a == AW'(12 + 8 * k)) return 4;
         if (a == AW'(16 + 8 * k)) return 5;
      end
      return 0;
   endfunction

   function automatic logic [31:0] exp_read(logic [AW-1:0] a);
      case (kind_of(a))
         1: return 32'(N) << 8;
         2: return {29'h0, m_ctrl};
         3: return {28'h0, m_sel};
         4: return m_base[m_sel] | {28'h0, m_sel};
         5: return {m_attr[m_sel], m_size[m_sel]};
         default: return 32'h0;
      endcase
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // apply one write at a negedge, update model, check pulse at next negedge
   task automatic do_write(logic [AW-1:0] a, logic [31:0] d, string req);
      logic       acc;
      logic [3:0] idx;
      acc = 1'b0;
      case (kind_of(a))
         2: begin m_ctrl = d[2:0]; acc = 1'b1; end
         3: if (d < 32'(N)) m_sel = d[3:0];
         4: begin
            idx = d[4] ? d[3:0] : m_sel;
            if (32'(idx) < 32'(N)) begin
               if (d[4]) m_sel = idx;
               m_base[idx] = d & 32'hFFFF_FFE0;
               acc = 1'b1;
            end
         end
         5: if (32'(m_sel) < 32'(N)) begin
            m_size[m_sel] = d[15:0] & 16'hFF3F;
            m_attr[m_sel] = d[31:16] & 16'h173F;
            acc = 1'b1;
         end
         default: ;
      endcase
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
      check({req, " R9 pulse"}, {31'h0, prot_inval}, {31'h0, acc});
   endtask

   task automatic do_read(logic [AW-1:0] a, string req);
      reg_addr = a;
      #1;
      check(req, reg_rdata, exp_read(a));
      @(negedge clk);
   endtask

   function automatic logic [AW-1:0] pick_addr();
      int r;
      r = int'($urandom % 13);
      if (r < 11) return AW'(r * 4);
      return AW'($urandom % 64);
   endfunction

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd20240611);
      m_sel = '0; m_ctrl = '0;
      for (int i = 0; i < 16; i++) begin
         m_base[i] = '0; m_size[i] = '0; m_attr[i] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: reset state
      check("R10 inval", {31'h0, prot_inval}, 32'h0);
      do_read(6'h04, "R10 ctrl");
      do_read(6'h08, "R10 sel");
      do_read(6'h0C, "R10 base");
      do_read(6'h10, "R10 attr");

      // R1: identification word and write immunity
      do_read(6'h00, "R1 ident");
      check("R1 ident value", exp_read(6'h00), 32'h0000_0800);
      do_write(6'h00, 32'hFFFF_FFFF, "R1");
      do_read(6'h00, "R1 ident after write");

      // R2: control masking and pulse
      do_write(6'h04, 32'hFFFF_FFFF, "R2");
      do_read(6'h04, "R2 ctrl masked");
      check("R2 ctrl value", exp_read(6'h04), 32'h7);
      // R9: pulse lasts one cycle
      check("R9 pulse drops", {31'h0, prot_inval}, 32'h0);

      // R3: select in range, then out of range
      do_write(6'h08, 32'd5, "R3");
      do_read(6'h08, "R3 sel=5");
      do_write(6'h08, 32'd8, "R3");
      do_read(6'h08, "R3 sel kept at 5");
      do_write(6'h08, 32'h1000_0002, "R3");
      do_read(6'h08, "R3 wide value kept");

      // R5: base stored with low bits cleared
      do_write(6'h0C, 32'hABCD_EF0F, "R5");
      do_read(6'h0C, "R5 base read");
      check("R5 base value", exp_read(6'h0C), 32'hABCD_EF05);

      // R4: redirect to region 3, then redirect out of range
      do_write(6'h14, 32'h1234_5013, "R4");
      do_read(6'h08, "R4 sel redirected");
      check("R4 sel value", exp_read(6'h08), 32'h3);
      do_write(6'h0C, 32'h5555_5019, "R4");
      do_read(6'h08, "R4 oob redirect keeps sel");
      do_read(6'h0C, "R4 oob redirect keeps base");
      do_write(6'h08, 32'd5, "R4");
      do_read(6'h0C, "R4 region 5 base intact");

      // R6: attribute/size masking
      do_write(6'h10, 32'hFFFF_FFFF, "R6");
      do_read(6'h10, "R6 attr read");
      check("R6 attr value", exp_read(6'h10), 32'h173F_FF3F);

      // R7: write through alias 2, read through aliases 0 and 3
      do_write(6'h20, 32'h0A0B_0C0D, "R7");
      do_read(6'h10, "R7 attr via alias 0");
      do_read(6'h28, "R7 attr via alias 3");
      do_write(6'h24, 32'h8000_0000, "R7");
      do_read(6'h0C, "R7 base via alias 0");

      // R8: unmapped offsets
      do_write(6'h30, 32'hFFFF_FFFF, "R8");
      do_read(6'h30, "R8 unmapped read");
      do_read(6'h0D, "R8 misaligned read");
      do_write(6'h0E, 32'h0000_0010, "R8");
      do_read(6'h08, "R8 sel untouched");

      // random mix
      for (int it = 0; it < 1500; it++) begin
         logic [AW-1:0] a;
         logic [31:0]   d;
         a = pick_addr();
         if ($urandom % 2 == 0) begin
            d = $urandom;
            case ($urandom % 4)
               0: d = d % 20;
               1: begin d[4] = 1'b1; d[3:0] = 4'(8 + ($urandom % 8)); end
               2: d[4] = 1'b1;
               default: ;
            endcase
            do_write(a, d, "R4/R6 random write");
         end else begin
            do_read(a, "R5/R7 random read");
         end
      end

      // R9: quiet after idle
      @(negedge clk);
      check("R9 idle quiet", {31'h0, prot_inval}, 32'h0);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule